// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block takes configuration writes from a slow three-wire serial link (a frame-enable line, a serial clock and a serial data line) and turns each complete frame into a parallel register write. A frame is 40 bits long. The first 8 bits select a register and the last 32 bits carry its new value, and both parts are sent most significant bit first. The sender raises the enable line before the first bit and lowers it after the last bit. It changes the data line only while the serial clock is low.

All three serial lines are resynchronized into the system clock domain. Edges of the serial clock and of the enable line are found from the resynchronized copies. A frame is accepted only when the enable line falls after exactly 40 captured bits. An accepted frame updates one of ten local registers and produces a one-cycle strobe on a parallel port that carries the address and the data. Other logic reads the register bank directly, or it watches the strobe to pick up changes. Entries 0 to 3 hold receive-channel frequency words and entries 4 to 7 hold transmit-channel frequency words. Entry 8 holds a rate-control word and entry 9 holds a miscellaneous-control word.

Top module: `cfg_rx_top`

## Requirements
- R1: While `rst` is high at a clock edge, every register in `regBank` is cleared to zero and `wrStrobe` is low after that edge.
- R2: A frame of exactly 40 serial-clock rising edges taken while enable is high produces, after enable falls, one `wrStrobe` pulse. At that pulse, `wrAddr` equals the first 8 bits received, with the first bit as bit 7, and `wrData` equals the following 32 bits, with the first of them as bit 31.
- R3: When an accepted frame has an address from 0 to 9, the 32-bit slice of `regBank` at bit offset address*32 takes the received data in the same cycle that `wrStrobe` is high.
- R4: When an accepted frame has an address of 10 or more, `wrStrobe` still pulses with that address and data, and `regBank` keeps its value.
- R5: A frame with fewer than 40 bits produces no strobe and leaves `regBank` unchanged. The next full frame is received correctly.
- R6: A frame with more than 40 bits produces no strobe and leaves `regBank` unchanged.
- R7: Rising edges of the serial clock while enable is low, including a trailing pulse right after a frame, shift nothing and cause no strobe.
- R8: `wrStrobe` is high for exactly one clock cycle per accepted frame.
- R9: A write changes only the addressed entry of `regBank`. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serEn | input | 1 | Frame enable, high for the whole frame |
| serClk | input | 1 | Serial clock; a bit is captured on its rising edge |
| serData | input | 1 | Serial data, most significant bit first |
| wrStrobe | output | 1 | One-cycle pulse for each accepted frame |
| wrAddr | output | 8 | Address of the last accepted frame |
| wrData | output | 32 | Data of the last accepted frame |
| regBank | output | 320 | Ten 32-bit registers; entry n is at bits n*32+31 down to n*32 |

## Verification
The checker assumes that the serial lines change much more slowly than the system clock. Each serial-clock level must last several system cycles, and the data line must change only while the serial clock is low. Under these conditions the synchronizers pass every edge and every data bit intact. The bench holds each serial-clock phase and each enable transition for four system cycles, and it changes data only in the low phase. It then varies the frame length, the address range and the presence of a trailing pulse, while keeping within those timing rules.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

  // Strobes passed from the control path to the datapath.
  typedef struct packed {
    logic clear;   // a new frame has begun
    logic shift;   // capture one serial bit
    logic commit;  // the frame is complete and valid
  } ctrlStrobes_t;

endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[gs] <= '0;
          else     chain[gs] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gs] <= '0;
          else     chain[gs] <= chain[gs-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/cfg_rx_ctrl.sv
module cfg_rx_ctrl
  import cfg_rx_pkg::*;
#(
  parameter int FRAME_BITS = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enSync,
  input  logic         clkSync,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic enPrev;
  logic clkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic enRise;
  logic enFall;
  logic clkRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      enPrev  <= enSync;
      clkPrev <= clkSync;
    end
  end

  always_comb begin
    enRise  = enSync & ~enPrev;
    enFall  = ~enSync & enPrev;
    clkRise = clkSync & ~clkPrev;
  end

  // Counts bits captured in the current frame and saturates at its top value.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (enRise) begin
      bitCnt <= '0;
    end else if (clkRise && enSync && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.clear  = enRise;
    strobes.shift  = clkRise & enSync & ~enRise;
    strobes.commit = enFall & (bitCnt == CNT_W'(FRAME_BITS));
  end

endmodule

// File: rtl/cfg_rx_datapath.sv
module cfg_rx_datapath
  import cfg_rx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobes_t               strobes,
  input  logic                       dataBit,
  output logic                       wrStrobe,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [DATA_W-1:0]          wrData,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [ADDR_W-1:0]     addrField;
  logic [DATA_W-1:0]     dataField;

  always_ff @(posedge clk) begin
    if (rst || strobes.clear) begin
      shiftReg <= '0;
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], dataBit};
    end
  end

  assign addrField = shiftReg[FRAME_BITS-1 -: ADDR_W];
  assign dataField = shiftReg[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= strobes.commit;
      if (strobes.commit) begin
        wrAddr <= addrField;
        wrData <= dataField;
      end
    end
  end

  // One register per defined address. Addresses with no register match no entry.
  genvar gr;
  generate
    for (gr = 0; gr < NUM_REGS; gr++) begin : g_reg
      logic [DATA_W-1:0] entry;
      always_ff @(posedge clk) begin
        if (rst) begin
          entry <= '0;
        end else if (strobes.commit && addrField == ADDR_W'(gr)) begin
          entry <= dataField;
        end
      end
      assign regBank[gr*DATA_W +: DATA_W] = entry;
    end
  endgenerate

endmodule

// File: rtl/cfg_rx_top.sv
module cfg_rx_top
  import cfg_rx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       serEn,
  input  logic                       serClk,
  input  logic                       serData,
  output logic                       wrStrobe,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [DATA_W-1:0]          wrData,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [2:0]   syncVec;
  ctrlStrobes_t strobes;

  cfg_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({serEn, serClk, serData}),
    .syncOut (syncVec)
  );

  cfg_rx_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enSync  (syncVec[2]),
    .clkSync (syncVec[1]),
    .strobes (strobes)
  );

  cfg_rx_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataBit  (syncVec[0]),
    .wrStrobe (wrStrobe),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .regBank  (regBank)
  );

endmodule

// File: rtl/cfg_rx_checker.sv
module cfg_rx_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wrStrobe,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [DATA_W-1:0]          wrData,
  input logic [NUM_REGS*DATA_W-1:0] regBank
);

  logic [DATA_W-1:0] selWord;
  logic              addrValid;

  always_comb begin
    selWord = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (wrAddr == ADDR_W'(k)) selWord = regBank[k*DATA_W +: DATA_W];
    end
    addrValid = (wrAddr < ADDR_W'(NUM_REGS));
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!wrStrobe && regBank == '0));

  assert_valid_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && addrValid) |-> (selWord == wrData));

  assert_bad_addr_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && !addrValid) |-> $stable(regBank));

  assert_single_cycle_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |=> !wrStrobe);

  assert_bank_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !wrStrobe |-> $stable(regBank));

endmodule

bind cfg_rx_top cfg_rx_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_checker (
  .clk(clk), .rst(rst), .wrStrobe(wrStrobe),
  .wrAddr(wrAddr), .wrData(wrData), .regBank(regBank)
);

// File: tb/test_cfg_rx_top.sv
module test_cfg_rx_top;

  localparam int NREG = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serEn = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic wrStrobe;
  logic [7:0] wrAddr;
  logic [31:0] wrData;
  logic [NREG*32-1:0] regBank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [39:0] expQ[$];
  logic [31:0] model [NREG];

  cfg_rx_top i_cfg_rx_top (
    .clk(clk), .rst(rst), .serEn(serEn), .serClk(serClk), .serData(serData),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .regBank(regBank)
  );

  always #2.5 clk = ~clk;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Driver: sends nbits of {addr,data} MSB first, and bits past 40 as zeros.
  task automatic sendFrame(input logic [7:0] a, input logic [31:0] d,
                           input int nbits, input bit trailing);
    logic [39:0] word;
    word = {a, d};
    if (nbits == 40) begin
      expQ.push_back(word);
      if (a < NREG) model[a] = d;
    end
    serEn = 1'b1;
    waitCyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      serData = (i < 40) ? word[39-i] : 1'b0;
      waitCyc(HALF);
      serClk = 1'b1;
      waitCyc(HALF);
      serClk = 1'b0;
    end
    waitCyc(HALF);
    serEn = 1'b0;
    waitCyc(HALF);
    if (trailing) begin
      serData = ~serData;
      serClk = 1'b1;
      waitCyc(HALF);
      serClk = 1'b0;
    end
    waitCyc(12);
  endtask

  task automatic checkBank(input string req);
    for (int k = 0; k < NREG; k++) begin
      check(regBank[k*32 +: 32] == model[k], req,
            $sformatf("entry %0d actual %h expected %h", k, regBank[k*32 +: 32], model[k]));
    end
  endtask

  // Monitor: pops expected writes as strobes appear and checks strobe width.
  logic prevStrobe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (wrStrobe && prevStrobe) begin
        check(1'b0, "R8", "strobe high two cycles actual 2 expected 1");
      end else if (wrStrobe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", $sformatf("unexpected strobe actual addr %h expected none", wrAddr));
        end else begin
          logic [39:0] e;
          e = expQ.pop_front();
          check({wrAddr, wrData} == e, "R2",
                $sformatf("actual %h expected %h", {wrAddr, wrData}, e));
        end
      end
    end
    prevStrobe = wrStrobe;
  end

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = '0;
    waitCyc(6);
    check(regBank == '0 && !wrStrobe, "R1",
          $sformatf("reset actual %h strobe %b expected 0", regBank[31:0], wrStrobe));
    rst = 1'b0;
    waitCyc(4);

    sendFrame(8'd0, 32'h1234_5678, 40, 1'b0);          // R2 R3
    checkBank("R3");
    sendFrame(8'd9, 32'hA5A5_0F0F, 40, 1'b0);          // R3 R9
    sendFrame(8'd4, 32'h8000_0001, 40, 1'b1);          // R7 trailing pulse
    checkBank("R9");
    sendFrame(8'd10, 32'hDEAD_BEEF, 40, 1'b0);         // R4
    sendFrame(8'hFF, 32'hFFFF_FFFF, 40, 1'b0);         // R4
    checkBank("R4");
    sendFrame(8'd5, 32'h1111_1111, 39, 1'b0);          // R5 short frame
    checkBank("R5");
    sendFrame(8'd5, 32'h2222_2222, 40, 1'b0);          // R5 recovery
    sendFrame(8'd6, 32'h3333_3333, 41, 1'b0);          // R6 long frame
    checkBank("R6");
    // R7: clock pulses with enable low
    for (int p = 0; p < 3; p++) begin
      serData = p[0];
      waitCyc(HALF);
      serClk = 1'b1;
      waitCyc(HALF);
      serClk = 1'b0;
    end
    waitCyc(12);
    checkBank("R7");
    sendFrame(8'd8, 32'h0BAD_F00D, 40, 1'b1);
    sendFrame(8'd8, 32'h0000_0000, 40, 1'b0);
    checkBank("R3");
    check(expQ.size() == 0, "R2", $sformatf("missing strobes actual %0d expected 0", expQ.size()));
    // R1: reset after writes
    rst = 1'b1;
    for (int k = 0; k < NREG; k++) model[k] = '0;
    waitCyc(3);
    checkBank("R1");
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "timeout actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule